// File: doc/BRIEF.md
# Synchronous Serial Port Controller with Collision and Mode-Fault Detection

This block moves one byte at a time over a four-wire synchronous serial link (SCK, MOSI, MISO, active-low SS). It acts either as the clock-driving master or as a slave that follows an external clock. A small register port gives a processor a control register, a status register and a data register. As master, a data write starts the transfer. As slave, the transfer advances only on SCK edges that arrive while SS is low. Clock idle level and sampling phase are programmable. A 3-bit field picks one of eight master clock divisors.

Two error detectors guard the link. A data write made while a byte is still in flight raises a collision flag and leaves the byte in flight untouched. If a master sees its SS input pulled low by another device, it raises a mode-fault flag, drops its master and enable bits, and releases every pin driver. The fault flag clears only when software reads the status register and then writes the control register.

Top module: `spi_port`

## Requirements
- R1: In master mode with the enable bit set, a write to the data register (address 2) starts a transfer. Bits leave on MOSI most significant first, bits from MISO are shifted in the same way, and after the eighth bit the received byte can be read at address 2.
- R2: In slave mode a data write only loads the outgoing byte. Bits move only on SCK input edges seen while SS is low, and SCK edges seen while SS is high start nothing.
- R3: Control bit 2 (polarity) sets the SCK idle level. With control bit 3 (phase) at 0, data is sampled on the leading SCK edge. With phase at 1, data is sampled on the trailing edge.
- R4: Control bits 6:4 hold a rate code r. As master, each SCK half period lasts 2^r system clocks, so the done flag rises 16*2^r clocks after the data write.
- R5: A data write while a transfer is busy sets the collision flag (status bit 6). The byte being shifted is not changed.
- R6: While enabled as master, SS low sets the mode-fault flag (status bit 4), clears control bits 0 (enable) and 1 (master), aborts the transfer, and deasserts the SCK, MOSI and MISO output enables.
- R7: The mode-fault flag clears only on a control write that follows a status read (address 1) made while the flag was set. A control write without that read leaves the flag set.
- R8: The MISO output enable is high only when enabled as slave with SS low. With phase 0 the slave presents its first bit on MISO as soon as SS falls.
- R9: The done flag (status bit 7) and the collision flag both clear on a read of the data register.
- R10: After reset the control and status registers read 0 and all output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives flag clearing) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| sck_i | input | 1 | Serial clock from the pin |
| sck_o | output | 1 | Serial clock to the pin |
| sck_oe | output | 1 | Serial clock driver enable |
| mosi_i | input | 1 | Master-out line from the pin |
| mosi_o | output | 1 | Master-out line to the pin |
| mosi_oe | output | 1 | Master-out driver enable |
| miso_i | input | 1 | Master-in line from the pin |
| miso_o | output | 1 | Master-in line to the pin |
| miso_oe | output | 1 | Master-in driver enable |
| ss_n_i | input | 1 | Active-low select from the pin |

## Verification
Master transfers cover all four combinations of polarity and phase. Rate codes run from 0 to 3 with 7 used in the error tests. The byte pairs include alternating, all-ones, all-zeros, single-bit and mixed patterns. An off-by-one bit order, a swapped sampling edge or a mis-sized divisor each shows up as a wrong captured byte or a wrong cycle count. Slave transfers are driven with each phase so that the leading-edge and trailing-edge paths are told apart, including the first MISO bit when SS falls. Directed cases use a slow rate so that a mid-transfer write or an SS pull-down lands inside a transfer.

// File: rtl/spi_port.sv
module spi_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       ss_n_i
);
  logic       en, mstr, cpol, cpha;
  logic [2:0] rate;
  logic [7:0] sh, rxb, cnt;
  logic       rxbit, active, sck_int, sck_prev;
  logic [3:0] e;
  logic       done, wcol, fault, arm;

  wire wr_ctl = wr_en && addr == 2'd0;
  wire wr_dat = wr_en && addr == 2'd2;
  wire rd_st  = rd_en && addr == 2'd1;
  wire rd_dat = rd_en && addr == 2'd2;

  wire [7:0] half_m1 = (8'd1 << rate) - 8'd1;
  wire busy      = mstr ? active : (e != 4'd0);
  wire s_edge    = en && !mstr && !ss_n_i && (sck_i != sck_prev);
  wire tick      = (mstr && active && cnt == half_m1) || s_edge;
  wire lead      = ~e[0];
  wire samp      = lead ^ cpha;
  wire last      = e == 4'd15;
  wire din       = mstr ? miso_i : mosi_i;
  wire [7:0] sh_nxt = {sh[6:0], (samp && last) ? din : rxbit};
  wire fault_hit = en && mstr && !ss_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; mstr <= 1'b0; cpol <= 1'b0; cpha <= 1'b0; rate <= 3'd0;
      sh <= 8'd0; rxb <= 8'd0; cnt <= 8'd0; rxbit <= 1'b0;
      active <= 1'b0; sck_int <= 1'b0; sck_prev <= 1'b0; e <= 4'd0;
      done <= 1'b0; wcol <= 1'b0; fault <= 1'b0; arm <= 1'b0;
    end else begin
      sck_prev <= sck_i;
      if (fault_hit) begin
        fault  <= 1'b1;
        arm    <= 1'b0;
        en     <= 1'b0;
        mstr   <= 1'b0;
        active <= 1'b0;
        e      <= 4'd0;
        cnt    <= 8'd0;
        sck_int <= cpol;
      end else begin
        if (wr_ctl) begin
          {rate, cpha, cpol, mstr, en} <= wdata[6:0];
          if (arm) begin
            fault <= 1'b0;
            arm   <= 1'b0;
          end
        end
        if (rd_st && fault) arm <= 1'b1;
        if (rd_dat) begin
          done <= 1'b0;
          wcol <= 1'b0;
        end
        if (wr_dat) begin
          if (busy) wcol <= 1'b1;
          else begin
            sh <= wdata;
            if (en && mstr) begin
              active <= 1'b1;
              cnt    <= 8'd0;
            end
          end
        end
        if (active) cnt <= (cnt == half_m1) ? 8'd0 : cnt + 8'd1;
        if (!active) sck_int <= cpol;
        else if (tick) sck_int <= ~sck_int;
        if (!en || (!mstr && ss_n_i)) begin
          e <= 4'd0;
          if (!en) active <= 1'b0;
        end else if (tick) begin
          e <= e + 4'd1;
          if (samp && !last) rxbit <= din;
          else if (samp || !(cpha && e == 4'd0)) sh <= sh_nxt;
          if (last) begin
            done   <= 1'b1;
            rxb    <= sh_nxt;
            active <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {1'b0, rate, cpha, cpol, mstr, en};
      2'd1:    rdata = {done, wcol, 1'b0, fault, 4'd0};
      2'd2:    rdata = rxb;
      default: rdata = 8'd0;
    endcase
  end

  assign sck_o   = sck_int;
  assign mosi_o  = sh[7];
  assign miso_o  = sh[7];
  assign sck_oe  = en && mstr && !fault;
  assign mosi_oe = en && mstr && !fault;
  assign miso_oe = en && !mstr && !ss_n_i && !fault;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic       ss_n_i,
  input logic       sck_oe,
  input logic       mosi_oe,
  input logic       miso_oe,
  input logic       en,
  input logic       mstr,
  input logic       busy,
  input logic       wcol,
  input logic       fault
);
  a_r6_fault_drivers_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!sck_oe && !mosi_oe && !miso_oe));

  a_r6_fault_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (!mstr && !en));

  a_r8_miso_oe_ss: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (!ss_n_i && !mstr));

  a_r5_wcol_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && busy && !(en && mstr && !ss_n_i)) |=> wcol);

  a_r2_slave_idle_ss_high: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mstr && ss_n_i) |=> !busy);
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .ss_n_i(ss_n_i),
  .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe), .en(en), .mstr(mstr),
  .busy(busy), .wcol(wcol), .fault(fault)
);

// File: tb/spi_port_test.sv
module spi_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {cpol, cpha, rate[2:0], tx byte, byte returned by the far end}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 3'd1, 8'hC3, 8'h5A},
    {1'b1, 1'b0, 3'd2, 8'h01, 8'h80},
    {1'b1, 1'b1, 3'd0, 8'hFF, 8'h00},
    {1'b0, 1'b0, 3'd3, 8'h6E, 8'h91},
    {1'b1, 1'b1, 3'd1, 8'h00, 8'hFF}
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic sck_i = 0, mosi_i = 0, miso_i = 0, ss_n_i = 1;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  int checks = 0, errors = 0;
  bit finished = 0;

  spi_port uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // far-end slave model used in master tests
  bit m_on = 0;
  logic mcpol, mcpha, p_sck, p_mosi;
  logic [7:0] mrx, cap;
  int k;
  always @(negedge clk) if (m_on) begin
    if (sck_o !== p_sck) begin
      if ((sck_o != mcpol) ^ mcpha) cap = {cap[6:0], p_mosi};
      else begin
        k++;
        if (k >= 0 && k < 8) miso_i = mrx[7-k];
      end
    end
    p_sck = sck_o;
    p_mosi = mosi_o;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a; rd_en = 1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    addr = 1;
    #1;
    while (!rdata[7] && n < 100000) begin
      @(negedge clk);
      n++;
      #1;
    end
  endtask

  task automatic start_model(input logic pol, input logic pha, input logic [7:0] rx);
    mcpol = pol; mcpha = pha; mrx = rx; cap = 0;
    k = pha ? -1 : 0;
    miso_i = pha ? 1'b0 : rx[7];
    p_sck = sck_o; p_mosi = mosi_o;
    m_on = 1;
  endtask

  task automatic mxfer(input logic pol, input logic pha, input logic [2:0] r,
                       input logic [7:0] tx, input logic [7:0] rx);
    int n;
    logic [7:0] v;
    wr(0, {1'b0, r, pha, pol, 2'b11});
    @(negedge clk);
    start_model(pol, pha, rx);
    wr(2, tx);
    wait_done(n);
    check("R4 cycles write to done", n, 16 << r);
    check("R1 byte seen on MOSI", cap, tx);
    check("R3 SCK back at idle level", sck_o, pol);
    rd(2, v);
    check("R1 received byte", v, rx);
    m_on = 0;
  endtask

  task automatic sxfer(input logic pol, input logic pha, input logic [7:0] load,
                       input logic [7:0] m);
    logic [7:0] got, v;
    sck_i = pol; ss_n_i = 1;
    wr(0, {1'b0, 3'd0, pha, pol, 2'b01});
    wr(2, load);
    #1 check("R8 MISO driver off while SS high", miso_oe, 0);
    @(negedge clk);
    ss_n_i = 0;
    repeat (2) @(negedge clk);
    check("R8 MISO driver on while SS low", miso_oe, 1);
    for (int i = 0; i < 8; i++) begin
      if (!pha) begin
        mosi_i = m[7-i];
        repeat (2) @(negedge clk);
        got[7-i] = miso_o;
        sck_i = ~pol;
        repeat (2) @(negedge clk);
        sck_i = pol;
        repeat (2) @(negedge clk);
      end else begin
        sck_i = ~pol;
        repeat (2) @(negedge clk);
        mosi_i = m[7-i];
        got[7-i] = miso_o;
        sck_i = pol;
        repeat (2) @(negedge clk);
      end
    end
    repeat (2) @(negedge clk);
    rd(1, v);
    check("R2 slave done flag", v[7], 1);
    check("R8 slave byte on MISO", got, load);
    rd(2, v);
    check("R2 slave received byte", v, m);
    ss_n_i = 1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    rd(0, v); check("R10 control after reset", v, 0);
    rd(1, v); check("R10 status after reset", v, 0);
    check("R10 output enables after reset", {sck_oe, mosi_oe, miso_oe}, 0);

    for (int i = 0; i < NVEC; i++)
      mxfer(VEC[i][20], VEC[i][19], VEC[i][18:16], VEC[i][15:8], VEC[i][7:0]);

    // R2: slave ignores write and SCK while SS high
    ss_n_i = 1;
    wr(0, 8'h01);
    wr(2, 8'h5A);
    for (int i = 0; i < 6; i++) begin
      sck_i = ~sck_i;
      repeat (2) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    rd(1, v); check("R2 no transfer with SS high", v[7], 0);
    check("R2 MISO driver stays off", miso_oe, 0);

    sxfer(1'b0, 1'b0, 8'hB4, 8'h2D);
    sxfer(1'b1, 1'b1, 8'h93, 8'hE6);

    // R5 write collision mid-transfer, R9 flag clearing
    wr(0, {1'b0, 3'd3, 2'b00, 2'b11});
    @(negedge clk);
    start_model(1'b0, 1'b0, 8'h00);
    wr(2, 8'hA5);
    repeat (20) @(negedge clk);
    wr(2, 8'h3C);
    rd(1, v); check("R5 collision flag set", v[6], 1);
    wait_done(n);
    check("R5 shifted byte untouched", cap, 8'hA5);
    m_on = 0;
    rd(2, v);
    rd(1, v); check("R9 done and collision cleared by data read", v, 0);

    // R6 mode fault mid-transfer, R7 clearing sequence
    wr(0, {1'b0, 3'd7, 2'b00, 2'b11});
    wr(2, 8'h81);
    repeat (10) @(negedge clk);
    ss_n_i = 0;
    @(negedge clk);
    #1 check("R6 drivers released on fault", {sck_oe, mosi_oe, miso_oe}, 0);
    rd(0, v); check("R6 enable and master cleared", v[1:0], 0);
    ss_n_i = 1;
    wr(0, 8'h03);
    rd(1, v); check("R7 fault kept without prior status read", v[4], 1);
    check("R6 drivers stay off while fault set", {sck_oe, mosi_oe}, 0);
    wr(0, 8'h00);
    rd(1, v); check("R7 fault cleared after status read then control write", v[4], 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule